// File: doc/BRIEF.md
# Debug Port Transaction Sequencer

This block runs one debug-port bus transaction at a time for a host that has already put together the request fields. The host supplies a transfer kind (OUT, IN or SETUP), a byte count of up to eight, a device/endpoint address word, the upper half of the packet-ID word, an eight-byte payload and a retry budget, and then pulses `go`. The sequencer chooses the token and data packet IDs and keeps the OUT data toggle. It passes the request to a handshake-level device model over a valid/ready channel and then waits for one response beat.

A NAK handshake or a response marked bad causes the sequencer to reissue the same request until the budget is used up. A response that never arrives ends the transfer with a timeout and raises a sticky not-safe flag. That flag blocks further work until software clears it. Completion is shown by a `done` flag, which stays set until it is cleared by a write of 1. An error code and the received length are reported with it.

Request channel rules: `dv_valid` rises only while the sequencer is issuing. Once raised, it stays high with every request field held unchanged until a cycle in which `dv_ready` is also high. The response channel has no back-pressure. The sequencer takes one `rsp_valid` beat per accepted request, and only while it is waiting.

Top module: `dbgseq_top`

## Requirements
- R1: After reset, `busy`, `done`, `unsafe`, `dv_valid` and `err_code` are all 0, and `pid_word` is 0.
- R2: A `go` that requests more than 8 bytes issues no request. On the next cycle `done` is 1, `err_code` is 3 (rejected) and `rx_len` is 0.
- R3: OUT (`xfer_kind` 0) uses token 0xE1. For each OUT transfer, the stored data PID is XORed with 0x88 before use. The first OUT after reset carries 0xC3, the next carries 0x4B, and so on. Retries within one transfer reuse the same value.
- R4: IN (`xfer_kind` 1) uses token 0x69 with data PID 0xC3. SETUP (`xfer_kind` 2 or 3) uses token 0x2D with data PID 0xC3 and always sends 8 bytes, whatever the requested count.
- R5: `pid_word` is {`pid_hi`, data PID, token} of the transfer most recently started. Bits 31:16 are taken unchanged from `pid_hi`.
- R6: A NAK handshake (0x5A) causes a reissue. The number of attempts is at most max(`retry_budget`, 1). If the budget runs out on a NAK, the transfer completes with `err_code` 0 and `rx_len` 0.
- R7: A response with `rsp_bad` set is retried within the same budget. If the budget runs out, `err_code` is 1 (bad) and `rx_len` is 0.
- R8: If no response arrives within TIMEOUT cycles of an accepted request, the transfer ends without retry. `err_code` becomes 2 and `unsafe` becomes 1. `unsafe` holds until `unsafe_clr` is pulsed, and any `go` given while it is set is ignored.
- R9: `busy` is 1 from the cycle after an accepted `go` until completion. A `go` given while busy is ignored.
- R10: `done` stays 1 until `done_clr` is pulsed or the next `go` is accepted.
- R11: Payloads are little-endian, with byte i at bits 8i+7:8i. Request bytes at or beyond the sent count go out as zero. `rx_data` keeps only the first `rx_len` bytes of the response and zeroes the rest.
- R12: While `dv_valid` is 1 and `dv_ready` is 0, `dv_valid` and all request fields keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse |
| xfer_kind | input | 2 | 0 OUT, 1 IN, 2/3 SETUP |
| xfer_len | input | 4 | Requested byte count |
| xfer_addr | input | 16 | Device/endpoint address word |
| pid_hi | input | 16 | Upper half of the PID word, kept as given |
| xfer_data | input | 64 | Outgoing payload, little-endian |
| retry_budget | input | 16 | Maximum attempts (0 means 1) |
| done_clr | input | 1 | Write-1 clear of `done` |
| unsafe_clr | input | 1 | Clears the not-safe flag |
| busy | output | 1 | Transfer in flight |
| done | output | 1 | Transfer finished |
| err_code | output | 2 | 0 none, 1 bad, 2 timeout, 3 rejected |
| rx_len | output | 4 | Length reported by the last response |
| rx_data | output | 64 | Received payload, masked to `rx_len` |
| pid_word | output | 32 | {pid_hi, data PID, token} of the last transfer |
| unsafe | output | 1 | Sticky not-safe flag |
| dv_valid | output | 1 | Request valid |
| dv_ready | input | 1 | Device accepts request |
| dv_token | output | 8 | Token PID |
| dv_data_pid | output | 8 | Data PID |
| dv_addr | output | 16 | Address word |
| dv_len | output | 4 | Bytes sent |
| dv_payload | output | 64 | Masked payload |
| rsp_valid | input | 1 | Response beat |
| rsp_pid | input | 8 | Handshake PID returned |
| rsp_bad | input | 1 | Bad-transaction indication |
| rsp_len | input | 4 | Length returned |
| rsp_data | input | 64 | Data returned |

## Verification
The hardest point to reach is the edge of the retry budget. There the final attempt meets a NAK or a bad response, and that attempt alone decides between a clean finish and an error. The device model in the bench is scripted to fail the first N attempts of each transfer. Directed cases put N just below, at and above the budget, including a budget of zero. A random phase then draws budgets and failure counts from small overlapping ranges, so these edges recur many times, with random `dv_ready` stalls applied throughout. The timeout path depends on a device that never answers. It is reached by silencing the model with a shortened timeout parameter, and the sticky lockout is then probed with a `go` that must produce no request.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;
  localparam logic [7:0] PID_OUT    = 8'hE1;
  localparam logic [7:0] PID_IN     = 8'h69;
  localparam logic [7:0] PID_SETUP  = 8'h2D;
  localparam logic [7:0] PID_DATA0  = 8'hC3;
  localparam logic [7:0] PID_DATA1  = 8'h4B;
  localparam logic [7:0] PID_NAK    = 8'h5A;
  localparam logic [7:0] PID_FLIP   = 8'h88;

  localparam logic [1:0] KIND_OUT = 2'd0;
  localparam logic [1:0] KIND_IN  = 2'd1;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_BAD     = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_REJECT  = 2'd3
  } err_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/dbgseq_pidsel.sv
module dbgseq_pidsel
  import dbgseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] kind,
  output logic [7:0] token,
  output logic [7:0] data_pid
);
  logic [7:0] toggle_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      toggle_q <= PID_DATA1;
      token    <= 8'h00;
      data_pid <= 8'h00;
    end else if (start) begin
      if (kind == KIND_OUT) begin
        toggle_q <= toggle_q ^ PID_FLIP;
        token    <= PID_OUT;
        data_pid <= toggle_q ^ PID_FLIP;
      end else if (kind == KIND_IN) begin
        token    <= PID_IN;
        data_pid <= PID_DATA0;
      end else begin
        token    <= PID_SETUP;
        data_pid <= PID_DATA0;
      end
    end
  end
endmodule

// File: rtl/dbgseq_retry.sv
module dbgseq_retry #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] budget,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      left_q <= '0;
    else if (load)   left_q <= (budget == '0) ? W'(1) : budget;
    else if (dec)    left_q <= left_q - W'(1);
  end

  assign last = (left_q <= W'(1));
endmodule

// File: rtl/dbgseq_timer.sv
module dbgseq_timer #(
  parameter int LIMIT = 250000,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else                cnt_q <= cnt_q + W'(1);
  end

  assign expired = run && (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/dbgseq_top.sv
module dbgseq_top
  import dbgseq_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int BUDGET_W  = 16,
  parameter int TIMEOUT   = 250000,
  parameter int ADDR_W    = 16,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int DATA_W   = MAX_BYTES * 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [1:0]          xfer_kind,
  input  logic [LEN_W-1:0]    xfer_len,
  input  logic [ADDR_W-1:0]   xfer_addr,
  input  logic [15:0]         pid_hi,
  input  logic [DATA_W-1:0]   xfer_data,
  input  logic [BUDGET_W-1:0] retry_budget,
  input  logic                done_clr,
  input  logic                unsafe_clr,
  output logic                busy,
  output logic                done,
  output logic [1:0]          err_code,
  output logic [LEN_W-1:0]    rx_len,
  output logic [DATA_W-1:0]   rx_data,
  output logic [31:0]         pid_word,
  output logic                unsafe,
  output logic                dv_valid,
  input  logic                dv_ready,
  output logic [7:0]          dv_token,
  output logic [7:0]          dv_data_pid,
  output logic [ADDR_W-1:0]   dv_addr,
  output logic [LEN_W-1:0]    dv_len,
  output logic [DATA_W-1:0]   dv_payload,
  input  logic                rsp_valid,
  input  logic [7:0]          rsp_pid,
  input  logic                rsp_bad,
  input  logic [LEN_W-1:0]    rsp_len,
  input  logic [DATA_W-1:0]   rsp_data
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_BYTES);

  function automatic logic [DATA_W-1:0] keep_bytes(
    input logic [DATA_W-1:0] d, input logic [LEN_W-1:0] n);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < MAX_BYTES; i++)
      r[8*i +: 8] = (i < int'(n)) ? d[8*i +: 8] : 8'h00;
    return r;
  endfunction

  seq_state_t          state_q;
  err_t                err_q;
  logic                done_q, unsafe_q;
  logic [LEN_W-1:0]    len_q, rxlen_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q, rxdata_q;
  logic [15:0]         pidhi_q;

  logic accept_go, too_long, start, retry_ev, last_try, expired;
  logic [7:0] tok, dpid;
  logic [LEN_W-1:0] eff_len;

  assign accept_go = go && (state_q == ST_IDLE) && !unsafe_q;
  assign too_long  = xfer_len > FULL_LEN;
  assign start     = accept_go && !too_long;
  assign eff_len   = xfer_kind[1] ? FULL_LEN : xfer_len;
  assign retry_ev  = (state_q == ST_WAIT) && rsp_valid &&
                     ((rsp_pid == PID_NAK) || rsp_bad) && !last_try;

  dbgseq_pidsel u_pidsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .kind     (xfer_kind),
    .token    (tok),
    .data_pid (dpid)
  );

  dbgseq_retry #(.W(BUDGET_W)) u_retry (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .budget (retry_budget),
    .dec    (retry_ev),
    .last   (last_try)
  );

  dbgseq_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state_q == ST_WAIT),
    .expired (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      err_q    <= ERR_NONE;
      done_q   <= 1'b0;
      unsafe_q <= 1'b0;
      len_q    <= '0;
      rxlen_q  <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      rxdata_q <= '0;
      pidhi_q  <= '0;
    end else begin
      if (done_clr)   done_q   <= 1'b0;
      if (unsafe_clr) unsafe_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_go && too_long) begin
            done_q  <= 1'b1;
            err_q   <= ERR_REJECT;
            rxlen_q <= '0;
          end else if (start) begin
            done_q  <= 1'b0;
            len_q   <= eff_len;
            addr_q  <= xfer_addr;
            data_q  <= keep_bytes(xfer_data, eff_len);
            pidhi_q <= pid_hi;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (dv_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (retry_ev) begin
              state_q <= ST_ISSUE;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
              if (rsp_bad) begin
                err_q    <= ERR_BAD;
                rxlen_q  <= '0;
                rxdata_q <= '0;
              end else if (rsp_pid == PID_NAK) begin
                err_q    <= ERR_NONE;
                rxlen_q  <= '0;
                rxdata_q <= '0;
              end else begin
                err_q    <= ERR_NONE;
                rxlen_q  <= rsp_len;
                rxdata_q <= keep_bytes(rsp_data, rsp_len);
              end
            end
          end else if (expired) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            err_q    <= ERR_TIMEOUT;
            unsafe_q <= 1'b1;
            rxlen_q  <= '0;
            rxdata_q <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign err_code    = err_q;
  assign rx_len      = rxlen_q;
  assign rx_data     = rxdata_q;
  assign unsafe      = unsafe_q;
  assign pid_word    = {pidhi_q, dpid, tok};
  assign dv_valid    = (state_q == ST_ISSUE);
  assign dv_token    = tok;
  assign dv_data_pid = dpid;
  assign dv_addr     = addr_q;
  assign dv_len      = len_q;
  assign dv_payload  = data_q;
endmodule

// File: rtl/dbgseq_chk.sv
module dbgseq_chk
  import dbgseq_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int DATA_W   = MAX_BYTES * 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic              busy,
  input logic              done,
  input logic              unsafe,
  input logic              unsafe_clr,
  input logic              dv_valid,
  input logic              dv_ready,
  input logic [7:0]        dv_token,
  input logic [7:0]        dv_data_pid,
  input logic [LEN_W-1:0]  dv_len,
  input logic [DATA_W-1:0] dv_payload
);
  assert_hold_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dv_valid && !dv_ready |=> dv_valid && $stable(dv_payload) &&
      $stable(dv_token) && $stable(dv_data_pid) && $stable(dv_len));

  assert_out_pid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dv_valid && (dv_token == PID_OUT) |->
      (dv_data_pid == PID_DATA0) || (dv_data_pid == PID_DATA1));

  assert_in_setup_pid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dv_valid && ((dv_token == PID_IN) || (dv_token == PID_SETUP)) |->
      dv_data_pid == PID_DATA0);

  assert_setup_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dv_valid && (dv_token == PID_SETUP) |-> dv_len == LEN_W'(MAX_BYTES));

  assert_len_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dv_valid |-> dv_len <= LEN_W'(MAX_BYTES));

  assert_unsafe_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unsafe && !unsafe_clr |=> unsafe);

  assert_unsafe_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && unsafe && go |=> !busy);

  assert_valid_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dv_valid |-> busy);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind dbgseq_top dbgseq_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .go          (go),
  .busy        (busy),
  .done        (done),
  .unsafe      (unsafe),
  .unsafe_clr  (unsafe_clr),
  .dv_valid    (dv_valid),
  .dv_ready    (dv_ready),
  .dv_token    (dv_token),
  .dv_data_pid (dv_data_pid),
  .dv_len      (dv_len),
  .dv_payload  (dv_payload)
);

// File: tb/tb_dbgseq_top.sv
module tb_dbgseq_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go = 1'b0, done_clr = 1'b0, unsafe_clr = 1'b0;
  logic [1:0] xfer_kind = 2'd0;
  logic [3:0] xfer_len = 4'd0;
  logic [15:0] xfer_addr = 16'h0, pid_hi = 16'h0, retry_budget = 16'd1;
  logic [63:0] xfer_data = 64'h0;
  logic busy, done, unsafe, dv_valid, dv_ready = 1'b0;
  logic [1:0] err_code;
  logic [3:0] rx_len, dv_len;
  logic [63:0] rx_data, dv_payload;
  logic [31:0] pid_word;
  logic [7:0] dv_token, dv_data_pid;
  logic [15:0] dv_addr;
  logic rsp_valid = 1'b0, rsp_bad = 1'b0;
  logic [7:0] rsp_pid = 8'h0;
  logic [3:0] rsp_len = 4'h0;
  logic [63:0] rsp_data = 64'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgseq_top #(.TIMEOUT(TMO)) dut (.*);

  int checks = 0, errors = 0, cyc = 0;

  // device model state
  int m_mode = 0, m_nn = 0, att_base = 0, m_attempts = 0, m_idx = 0, dly = 0;
  int pid_drift = 0, stab_err = 0;
  logic [3:0] m_in_len = 4'd0;
  logic [63:0] m_in_data = 64'h0;
  logic [7:0] c_tok = 8'h0, c_pid = 8'h0, first_pid = 8'h0;
  logic [3:0] c_len = 4'h0;
  logic [15:0] c_addr = 16'h0;
  logic [63:0] c_pay = 64'h0, p_pay = 64'h0;
  logic [7:0] p_tok = 8'h0;
  logic stall_prev = 1'b0;

  always @(posedge clk) begin
    int idx;
    logic fail_now;
    rsp_valid <= 1'b0;
    dv_ready <= ($urandom % 4) != 0;
    stall_prev <= dv_valid && !dv_ready;
    p_pay <= dv_payload;
    p_tok <= dv_token;
    if (stall_prev && (!dv_valid || dv_payload != p_pay || dv_token != p_tok))
      stab_err <= stab_err + 1;
    if (dv_valid && dv_ready) begin
      idx = m_attempts - att_base;
      m_attempts <= m_attempts + 1;
      m_idx <= idx;
      c_tok <= dv_token; c_pid <= dv_data_pid; c_len <= dv_len;
      c_addr <= dv_addr; c_pay <= dv_payload;
      if (idx == 0) first_pid <= dv_data_pid;
      else if (dv_data_pid != first_pid) pid_drift <= pid_drift + 1;
      dly <= 2;
    end else if (dly > 0) begin
      dly <= dly - 1;
      if (dly == 1 && m_mode != 3) begin
        fail_now = (m_mode == 1 || m_mode == 2) && (m_idx < m_nn);
        rsp_valid <= 1'b1;
        rsp_pid <= (m_mode == 1 && fail_now) ? 8'h5A : 8'hD2;
        rsp_bad <= (m_mode == 2 && fail_now);
        rsp_len <= fail_now ? 4'd0 : ((c_tok == 8'h69) ? m_in_len : c_len);
        rsp_data <= (c_tok == 8'h69) ? m_in_data : 64'h0;
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] keep(input logic [63:0] d, input int n);
    logic [63:0] r = 64'h0;
    for (int i = 0; i < 8; i++) if (i < n) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  function automatic int max1(input int b);
    return (b < 1) ? 1 : b;
  endfunction

  logic [7:0] exp_tog = 8'h4B;

  // Runs one transfer; poke pulses a second go while busy (R9).
  task automatic run_xfer(input logic [1:0] k, input int len, input logic [63:0] d,
                          input int budget, input int mode, input int nn, input bit poke);
    int exp_att, exp_err, exp_rx, eff, waitc, att, b1;
    logic [7:0] exp_tok, exp_pid;
    logic [15:0] hi, ad;
    logic saw_busy;
    hi = 16'($urandom); ad = 16'($urandom);
    m_mode = mode; m_nn = nn; att_base = m_attempts;
    @(negedge clk);
    xfer_kind = k; xfer_len = 4'(len); xfer_data = d; retry_budget = 16'(budget);
    pid_hi = hi; xfer_addr = ad; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    saw_busy = busy;
    if (poke) begin
      xfer_kind = 2'd1; xfer_len = 4'd2; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
    end
    waitc = 0;
    while (!done && waitc < 3000) begin @(negedge clk); waitc++; end
    att = m_attempts - att_base;
    b1 = max1(budget);
    eff = (k >= 2) ? 8 : len;
    exp_tok = (k == 0) ? 8'hE1 : (k == 1) ? 8'h69 : 8'h2D;
    exp_pid = 8'hC3;
    if (len > 8) begin
      chk("R2 reject err", 64'(err_code), 64'd3);
      chk("R2 no request", 64'(att), 64'd0);
      chk("R2 rx_len", 64'(rx_len), 64'd0);
      chk("R2 done", 64'(done), 64'd1);
      return;
    end
    if (k == 0) begin exp_tog = exp_tog ^ 8'h88; exp_pid = exp_tog; end
    exp_rx = (k == 1) ? int'(m_in_len) : eff;
    case (mode)
      1: begin exp_att = (nn + 1 < b1) ? nn + 1 : b1; exp_err = 0;
               if (nn + 1 > b1) exp_rx = 0; end
      2: begin exp_att = (nn + 1 < b1) ? nn + 1 : b1;
               exp_err = (nn + 1 <= b1) ? 0 : 1; if (exp_err != 0) exp_rx = 0; end
      3: begin exp_att = 1; exp_err = 2; exp_rx = 0; end
      default: begin exp_att = 1; exp_err = 0; end
    endcase
    chk("R9 busy after go", 64'(saw_busy), 64'd1);
    chk("R10 done set", 64'(done), 64'd1);
    chk("R6/R7 attempts", 64'(att), 64'(exp_att));
    chk("R7/R8 err_code", 64'(err_code), 64'(exp_err));
    chk("R6 rx_len", 64'(rx_len), 64'(exp_rx));
    chk("R3/R4 token", 64'(c_tok), 64'(exp_tok));
    chk("R3/R4 data pid", 64'(c_pid), 64'(exp_pid));
    chk("R4 sent len", 64'(c_len), 64'(eff));
    chk("R11 payload", c_pay, keep(d, eff));
    chk("R5 pid_word", 64'(pid_word), 64'({hi, exp_pid, exp_tok}));
    chk("R5 addr", 64'(c_addr), 64'(ad));
    if (k == 1) chk("R11 rx_data", rx_data, keep(m_in_data, exp_rx));
    chk("R8 unsafe", 64'(unsafe), (mode == 3) ? 64'd1 : 64'd0);
    chk("R3 pid steady across retries", 64'(pid_drift), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 unsafe", 64'(unsafe), 64'd0);
    chk("R1 dv_valid", 64'(dv_valid), 64'd0);
    chk("R1 err", 64'(err_code), 64'd0);
    chk("R1 pid_word", 64'(pid_word), 64'd0);

    run_xfer(2'd0, 3, 64'h8877665544332211, 5, 0, 0, 1'b0);   // R3 first OUT C3
    run_xfer(2'd0, 8, 64'h0102030405060708, 5, 0, 0, 1'b0);   // R3 second OUT 4B
    run_xfer(2'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 5, 0, 0, 1'b0);
    run_xfer(2'd0, 4, 64'hDEADBEEF_CAFEF00D, 10, 1, 2, 1'b0); // R6 NAK then ACK
    run_xfer(2'd0, 2, 64'h1234, 4, 1, 100, 1'b0);             // R6 budget used up
    run_xfer(2'd1, 1, 64'h0, 0, 1, 5, 1'b0);                  // R6 budget 0
    run_xfer(2'd0, 1, 64'h55, 3, 1, 2, 1'b0);                 // R6 ack on last try
    m_in_len = 4'd5; m_in_data = 64'hA1A2A3A4A5A6A7A8;
    run_xfer(2'd1, 8, 64'h0, 3, 0, 0, 1'b0);                  // R4/R11 IN
    run_xfer(2'd2, 2, 64'h1122334455667788, 3, 0, 0, 1'b0);   // R4 SETUP
    run_xfer(2'd2, 9, 64'h0, 3, 0, 0, 1'b0);                  // R2 reject
    run_xfer(2'd0, 9, 64'h0, 3, 0, 0, 1'b0);                  // R2 reject, no toggle
    run_xfer(2'd0, 6, 64'hABCDEF, 3, 2, 3, 1'b0);             // R7 bad exhausted
    run_xfer(2'd0, 6, 64'hABCDEF, 3, 2, 2, 1'b0);             // R7 recover on last
    run_xfer(2'd0, 5, 64'h99, 10, 1, 3, 1'b1);                // R9 go while busy

    // R10 done clear
    @(negedge clk); done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    chk("R10 done cleared", 64'(done), 64'd0);

    // R8 timeout and lockout
    run_xfer(2'd0, 2, 64'h77, 5, 3, 0, 1'b0);
    begin
      int base, seen;
      base = m_attempts; seen = 0;
      @(negedge clk); xfer_kind = 2'd1; xfer_len = 4'd1; go = 1'b1;
      @(negedge clk); go = 1'b0;
      for (int i = 0; i < 20; i++) begin
        if (busy) seen++;
        @(negedge clk);
      end
      chk("R8 go ignored busy", 64'(seen), 64'd0);
      chk("R8 go ignored req", 64'(m_attempts - base), 64'd0);
      chk("R8 still unsafe", 64'(unsafe), 64'd1);
      chk("R8 done kept", 64'(done), 64'd1);
      unsafe_clr = 1'b1; @(negedge clk); unsafe_clr = 1'b0;
      chk("R8 unsafe cleared", 64'(unsafe), 64'd0);
    end
    run_xfer(2'd0, 3, 64'h3333, 2, 0, 0, 1'b0);

    // constrained random phase
    for (int n = 0; n < 40; n++) begin
      m_in_len = 4'($urandom % 9);
      m_in_data = {$urandom, $urandom};
      run_xfer(2'($urandom % 3), int'($urandom % 10), {$urandom, $urandom},
               int'($urandom % 6), int'($urandom % 3), int'($urandom % 5), 1'b0);
    end
    chk("R12 request held while stalled", 64'(stab_err), 64'd0);

    summary();
    $finish;
  end
endmodule